// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches a bank of up to 32 already-debounced input pins and turns selected transitions or levels into interrupt events. Each pin has its own trigger mode, chosen by one bit in each of three mode registers. A sticky flag register records the events, and software clears a flag by writing one to it. A single interrupt line is raised while any flagged pin is also armed.

Software reaches the block through a simple synchronous register port: a one-cycle write strobe with a byte offset and data, plus a read data bus that follows the offset combinationally. Pins that have no input capability are removed at elaboration by a mask parameter. For those pins every configuration bit reads as zero and the flag never sets.

Top module: `gpio_evt_bank`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, every register reads 0 and `irq_out` is low.
- R2: The register offsets are: arm at 0x00, mode A at 0x04, mode B at 0x08, mode C at 0x0C and flags at 0x10. A written value reads back at the same offset. Any other offset reads 0.
- R3: Mode bits (A,B,C) = (0,0,x) select falling edge. The flag sets on the clock edge after a pin goes from 1 to 0, and a 0-to-1 change leaves it clear.
- R4: Mode bits (1,0,0) select rising edge. The flag sets after a 0-to-1 change and not after a 1-to-0 change.
- R5: Mode bits (1,0,1) select both edges. The flag sets after either change.
- R6: Mode B = 1 selects level detection: active low when A = 0, active high when A = 1. The flag is set again on every clock while the level stays active, even right after it is cleared.
- R7: A write of 1 to a flag bit at 0x10 clears that bit. A written 0 leaves the bit unchanged. Without a flag write, a set flag bit never clears.
- R8: When an event and a clearing write hit the same flag bit in the same cycle, the bit stays set.
- R9: `irq_out` is high exactly when some pin has both its flag bit and its arm bit set.
- R10: For a pin whose bit is 0 in `INPUT_MASK`, the arm and mode bits read 0 whatever is written, and the flag bit never sets.
- R11: The edge history of each pin is loaded from the pin during reset. A pin that is already high when reset ends therefore produces no rising event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_in | input | PIN_COUNT | Debounced pin levels, synchronous to clk |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Register byte offset for writes and reads |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench drives single-pin transitions in both directions for each of the five trigger modes. This separates the edge modes from one another and from the level modes, and shows that a level source refires after it is cleared. Flag writes are issued with all-zero data, with a matching one, and in the same cycle as a fresh edge, which distinguishes a correct write-one-to-clear from a plain overwrite or a clear that wins. Arm patterns that cover and that miss the flagged pin separate the AND-then-OR combination from a bare OR of the flags. A masked pin and a pin held high across reset release cover the two places where an event must not appear.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

   // Register byte offsets; software decodes these.
   localparam int unsigned OFF_ARM    = 0;
   localparam int unsigned OFF_MODE_A = 4;
   localparam int unsigned OFF_MODE_B = 8;
   localparam int unsigned OFF_MODE_C = 12;
   localparam int unsigned OFF_FLAG   = 16;
   localparam int unsigned CFG_REGS   = 4;
   localparam int unsigned MIN_ADDR_W = 5;

   typedef enum logic [2:0] {
      TRIG_FALL,
      TRIG_RISE,
      TRIG_BOTH,
      TRIG_LOW,
      TRIG_HIGH
   } trig_e;

   function automatic trig_e trig_decode(input logic a, input logic b, input logic c);
      if (b)       return a ? TRIG_HIGH : TRIG_LOW;
      else if (!a) return TRIG_FALL;
      else         return c ? TRIG_BOTH : TRIG_RISE;
   endfunction

endpackage

// File: rtl/gpio_evt_pin.sv
module gpio_evt_pin
   import gpio_evt_pkg::*;
(
   input  logic clk,
   input  logic level,
   input  logic sel_a,
   input  logic sel_b,
   input  logic sel_c,
   output logic hit
);

   logic  last_q;
   trig_e kind;
   logic  went_up;
   logic  went_down;

   // History follows the pin every cycle, reset included.
   always_ff @(posedge clk) begin
      last_q <= level;
   end

   assign went_up   = level & ~last_q;
   assign went_down = ~level & last_q;

   always_comb begin
      kind = trig_decode(sel_a, sel_b, sel_c);
      case (kind)
         TRIG_FALL: hit = went_down;
         TRIG_RISE: hit = went_up;
         TRIG_BOTH: hit = went_up | went_down;
         TRIG_LOW:  hit = ~level;
         TRIG_HIGH: hit = level;
         default:   hit = 1'b0;
      endcase
   end

endmodule

// File: rtl/gpio_evt_cfg.sv
module gpio_evt_cfg
   import gpio_evt_pkg::*;
#(
   parameter int unsigned          PIN_COUNT  = 32,
   parameter int unsigned          ADDR_W     = 5,
   parameter logic [PIN_COUNT-1:0] INPUT_MASK = '1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [PIN_COUNT-1:0] wdata,
   output logic [PIN_COUNT-1:0] arm_q,
   output logic [PIN_COUNT-1:0] mode_a_q,
   output logic [PIN_COUNT-1:0] mode_b_q,
   output logic [PIN_COUNT-1:0] mode_c_q,
   output logic [PIN_COUNT-1:0] clr
);

   logic [PIN_COUNT-1:0] cfg_q [CFG_REGS];

   for (genvar r = 0; r < CFG_REGS; r++) begin : g_cfg
      localparam logic [ADDR_W-1:0] MY_OFF = ADDR_W'(r * 4);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cfg_q[r] <= '0;
         end else if (wr && addr == MY_OFF) begin
            cfg_q[r] <= wdata & INPUT_MASK;
         end
      end
   end

   assign arm_q    = cfg_q[OFF_ARM / 4];
   assign mode_a_q = cfg_q[OFF_MODE_A / 4];
   assign mode_b_q = cfg_q[OFF_MODE_B / 4];
   assign mode_c_q = cfg_q[OFF_MODE_C / 4];

   assign clr = (wr && addr == ADDR_W'(OFF_FLAG)) ? (wdata & INPUT_MASK) : '0;

endmodule

// File: rtl/gpio_evt_flags.sv
module gpio_evt_flags #(
   parameter int unsigned PIN_COUNT = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [PIN_COUNT-1:0] hit,
   input  logic [PIN_COUNT-1:0] clr,
   input  logic [PIN_COUNT-1:0] arm,
   output logic [PIN_COUNT-1:0] flag_q,
   output logic                 irq
);

   // A new hit outranks a clear of the same bit.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= '0;
      end else begin
         flag_q <= (flag_q & ~clr) | hit;
      end
   end

   assign irq = |(flag_q & arm);

endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank
   import gpio_evt_pkg::*;
#(
   parameter int unsigned          PIN_COUNT  = 32,
   parameter int unsigned          ADDR_W     = 5,
   parameter int unsigned          DATA_W     = 32,
   parameter logic [PIN_COUNT-1:0] INPUT_MASK = '1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [PIN_COUNT-1:0] pin_in,
   input  logic                 reg_wr,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [DATA_W-1:0]    reg_wdata,
   output logic [DATA_W-1:0]    reg_rdata,
   output logic                 irq_out
);

   if (PIN_COUNT < 1 || PIN_COUNT > DATA_W) begin : g_bad_pins
      $error("gpio_evt_bank: PIN_COUNT must lie in 1..DATA_W");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
      $error("gpio_evt_bank: ADDR_W too narrow for the flag offset");
   end

   logic [PIN_COUNT-1:0] arm_q;
   logic [PIN_COUNT-1:0] mode_a_q;
   logic [PIN_COUNT-1:0] mode_b_q;
   logic [PIN_COUNT-1:0] mode_c_q;
   logic [PIN_COUNT-1:0] clr_vec;
   logic [PIN_COUNT-1:0] hit_vec;
   logic [PIN_COUNT-1:0] flag_vec;
   logic [PIN_COUNT-1:0] rd_sel;

   gpio_evt_cfg #(
      .PIN_COUNT (PIN_COUNT),
      .ADDR_W    (ADDR_W),
      .INPUT_MASK(INPUT_MASK)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (reg_wr),
      .addr    (reg_addr),
      .wdata   (reg_wdata[PIN_COUNT-1:0]),
      .arm_q   (arm_q),
      .mode_a_q(mode_a_q),
      .mode_b_q(mode_b_q),
      .mode_c_q(mode_c_q),
      .clr     (clr_vec)
   );

   for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
      if (INPUT_MASK[p]) begin : g_live
         gpio_evt_pin u_pin (
            .clk  (clk),
            .level(pin_in[p]),
            .sel_a(mode_a_q[p]),
            .sel_b(mode_b_q[p]),
            .sel_c(mode_c_q[p]),
            .hit  (hit_vec[p])
         );
      end else begin : g_dead
         assign hit_vec[p] = 1'b0;
      end
   end

   gpio_evt_flags #(
      .PIN_COUNT(PIN_COUNT)
   ) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (hit_vec),
      .clr   (clr_vec),
      .arm   (arm_q),
      .flag_q(flag_vec),
      .irq   (irq_out)
   );

   always_comb begin
      case (reg_addr)
         ADDR_W'(OFF_ARM):    rd_sel = arm_q;
         ADDR_W'(OFF_MODE_A): rd_sel = mode_a_q;
         ADDR_W'(OFF_MODE_B): rd_sel = mode_b_q;
         ADDR_W'(OFF_MODE_C): rd_sel = mode_c_q;
         ADDR_W'(OFF_FLAG):   rd_sel = flag_vec;
         default:             rd_sel = '0;
      endcase
   end

   assign reg_rdata = DATA_W'(rd_sel);

endmodule

// File: rtl/gpio_evt_chk.sv
module gpio_evt_chk
   import gpio_evt_pkg::*;
#(
   parameter int unsigned          PIN_COUNT  = 32,
   parameter int unsigned          ADDR_W     = 5,
   parameter logic [PIN_COUNT-1:0] INPUT_MASK = '1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 reg_wr,
   input logic [ADDR_W-1:0]    reg_addr,
   input logic [PIN_COUNT-1:0] pin_in,
   input logic [PIN_COUNT-1:0] mode_a,
   input logic [PIN_COUNT-1:0] mode_b,
   input logic [PIN_COUNT-1:0] hit,
   input logic [PIN_COUNT-1:0] flag,
   input logic                 irq
);

   logic [PIN_COUNT-1:0] lvl_on;
   logic                 flag_wr;

   assign lvl_on  = mode_b & ((mode_a & pin_in) | (~mode_a & ~pin_in));
   assign flag_wr = reg_wr && (reg_addr == ADDR_W'(OFF_FLAG));

   AST_RESET_EMPTIES: assert property (@(posedge clk)
      !rst_n |=> (flag == '0)); // R1

   AST_LEVEL_REFIRES: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_on != '0) |=> ((flag & $past(lvl_on)) == $past(lvl_on))); // R6

   AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_wr |=> ((flag & $past(flag)) == $past(flag))); // R7

   AST_HIT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (hit != '0) |=> ((flag & $past(hit)) == $past(hit))); // R8

   AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flag != '0)); // R9

   AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (flag & ~INPUT_MASK) == '0); // R10

endmodule

bind gpio_evt_bank gpio_evt_chk #(
   .PIN_COUNT (PIN_COUNT),
   .ADDR_W    (ADDR_W),
   .INPUT_MASK(INPUT_MASK)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .reg_wr  (reg_wr),
   .reg_addr(reg_addr),
   .pin_in  (pin_in),
   .mode_a  (mode_a_q),
   .mode_b  (mode_b_q),
   .hit     (hit_vec),
   .flag    (flag_vec),
   .irq     (irq_out)
);

// File: tb/test_gpio_evt_bank.sv
module test_gpio_evt_bank;

   localparam int unsigned PINS = 32;
   localparam int unsigned AW   = 5;
   localparam int unsigned DW   = 32;
   localparam logic [31:0] MASK = 32'hFFFF_7FFF;

   localparam logic [4:0] A_ARM  = 5'h00;
   localparam logic [4:0] A_MA   = 5'h04;
   localparam logic [4:0] A_MB   = 5'h08;
   localparam logic [4:0] A_MC   = 5'h0C;
   localparam logic [4:0] A_FLAG = 5'h10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] pin_in;
   logic        reg_wr;
   logic [4:0]  reg_addr;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;
   logic        irq_out;

   always #4 clk = ~clk;

   gpio_evt_bank #(
      .PIN_COUNT (PINS),
      .ADDR_W    (AW),
      .DATA_W    (DW),
      .INPUT_MASK(MASK)
   ) i_gpio_evt_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_in   (pin_in),
      .reg_wr   (reg_wr),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .irq_out  (irq_out)
   );

   typedef struct {
      string       req;
      bit          on_irq;
      logic [31:0] exp;
   } item_t;

   item_t sb_q[$];
   event  probe_ev;
   int    checks = 0;
   int    fails  = 0;
   bit    done   = 1'b0;

   // Monitor: pops expected items and compares against the ports.
   initial begin
      forever begin
         @(probe_ev);
         while (sb_q.size() > 0) begin
            item_t       it;
            logic [31:0] act;
            it  = sb_q.pop_front();
            act = it.on_irq ? {31'b0, irq_out} : reg_rdata;
            checks++;
            if (act !== it.exp) begin
               fails++;
               $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
            end
         end
      end
   end

   task automatic expect_reg(input logic [4:0] a, input logic [31:0] e, input string r);
      @(negedge clk);
      reg_addr = a;
      #1;
      sb_q.push_back('{r, 1'b0, e});
      -> probe_ev;
      #1;
   endtask

   task automatic expect_irq(input logic e, input string r);
      @(negedge clk);
      #1;
      sb_q.push_back('{r, 1'b1, {31'b0, e}});
      -> probe_ev;
      #1;
   endtask

   task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr    = 1'b1;
      reg_addr  = a;
      reg_wdata = d;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic write_with_pins(input logic [4:0] a, input logic [31:0] d,
                                  input logic [31:0] v);
      @(negedge clk);
      reg_wr    = 1'b1;
      reg_addr  = a;
      reg_wdata = d;
      pin_in    = v;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic set_pins(input logic [31:0] v);
      @(negedge clk);
      pin_in = v;
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R1 watchdog actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      rst_n     = 1'b0;
      reg_wr    = 1'b0;
      reg_addr  = '0;
      reg_wdata = '0;
      pin_in    = 32'h0000_0013;   // pins 0, 1 and 4 high from the start
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: every register and the line are clear after reset
      expect_reg(A_ARM,  32'h0, "R1");
      expect_reg(A_MA,   32'h0, "R1");
      expect_reg(A_MB,   32'h0, "R1");
      expect_reg(A_MC,   32'h0, "R1");
      expect_reg(A_FLAG, 32'h0, "R1");
      expect_irq(1'b0, "R1");

      // R11: pin 0 high through reset, switched to rising: no event
      reg_write(A_MA, 32'h0000_0001);
      expect_reg(A_FLAG, 32'h0, "R11");

      // R2: readback and unmapped offsets
      reg_write(A_MC, 32'hA5A5_A5A5);
      expect_reg(A_MC, 32'hA5A5_25A5, "R2");
      reg_write(A_MC, 32'h0);
      expect_reg(5'h14, 32'h0, "R2");
      expect_reg(5'h1C, 32'h0, "R2");

      // R10: masked pin 15 never takes a configuration bit
      reg_write(A_ARM, 32'hFFFF_FFFF);
      expect_reg(A_ARM, 32'hFFFF_7FFF, "R10");
      reg_write(A_ARM, 32'h0);

      // pin1 fall, pin2 rise, pin3 both, pin4 level low, pin5 level high
      reg_write(A_MA, 32'h0000_802D);
      reg_write(A_MB, 32'h0000_8030);
      reg_write(A_MC, 32'h0000_0008);
      expect_reg(A_MA, 32'h0000_002D, "R10");
      expect_reg(A_MB, 32'h0000_0030, "R2");
      expect_reg(A_FLAG, 32'h0, "R11");

      // R3: falling edge on pin 1
      set_pins(32'h0000_0011);
      expect_reg(A_FLAG, 32'h0000_0002, "R3");
      expect_irq(1'b0, "R9");
      reg_write(A_ARM, 32'h0000_0002);
      expect_irq(1'b1, "R9");
      reg_write(A_ARM, 32'h0);
      expect_irq(1'b0, "R9");

      // R7: zero write keeps, one write clears
      reg_write(A_FLAG, 32'h0);
      expect_reg(A_FLAG, 32'h0000_0002, "R7");
      reg_write(A_FLAG, 32'h0000_0002);
      expect_reg(A_FLAG, 32'h0, "R7");
      set_pins(32'h0000_0013);
      expect_reg(A_FLAG, 32'h0, "R3");

      // R4: rising only on pin 2
      set_pins(32'h0000_0017);
      expect_reg(A_FLAG, 32'h0000_0004, "R4");
      reg_write(A_FLAG, 32'h0000_0004);
      set_pins(32'h0000_0013);
      expect_reg(A_FLAG, 32'h0, "R4");

      // R5: both edges on pin 3
      set_pins(32'h0000_001B);
      expect_reg(A_FLAG, 32'h0000_0008, "R5");
      reg_write(A_FLAG, 32'h0000_0008);
      set_pins(32'h0000_0013);
      expect_reg(A_FLAG, 32'h0000_0008, "R5");
      reg_write(A_FLAG, 32'h0000_0008);
      expect_reg(A_FLAG, 32'h0, "R5");

      // R6: level low on pin 4 refires after a clear
      set_pins(32'h0000_0003);
      expect_reg(A_FLAG, 32'h0000_0010, "R6");
      reg_write(A_FLAG, 32'h0000_0010);
      expect_reg(A_FLAG, 32'h0000_0010, "R6");
      set_pins(32'h0000_0013);
      reg_write(A_FLAG, 32'h0000_0010);
      expect_reg(A_FLAG, 32'h0, "R6");
      // R6: level high on pin 5
      set_pins(32'h0000_0033);
      expect_reg(A_FLAG, 32'h0000_0020, "R6");
      set_pins(32'h0000_0013);
      reg_write(A_FLAG, 32'h0000_0020);
      expect_reg(A_FLAG, 32'h0, "R6");

      // R8: rising edge on pin 2 in the same cycle as its clear
      set_pins(32'h0000_0017);
      expect_reg(A_FLAG, 32'h0000_0004, "R8");
      set_pins(32'h0000_0013);
      write_with_pins(A_FLAG, 32'h0000_0004, 32'h0000_0017);
      expect_reg(A_FLAG, 32'h0000_0004, "R8");
      reg_write(A_FLAG, 32'h0000_0004);
      expect_reg(A_FLAG, 32'h0, "R8");
      set_pins(32'h0000_0013);

      // R10: toggling the masked pin leaves no flag
      set_pins(32'h0000_8013);
      set_pins(32'h0000_0013);
      expect_reg(A_FLAG, 32'h0, "R10");

      // R9: arm must cover the flagged pin
      set_pins(32'h0000_0011);
      expect_reg(A_FLAG, 32'h0000_0002, "R3");
      reg_write(A_ARM, 32'h0000_0004);
      expect_irq(1'b0, "R9");
      reg_write(A_ARM, 32'h0000_0006);
      expect_irq(1'b1, "R9");
      reg_write(A_FLAG, 32'h0000_0002);
      expect_irq(1'b0, "R9");

      done = 1'b1;
      finish_run();
   end

endmodule